// File: doc/BRIEF.md
# Socket Command and Status Controller

This block is the per-socket control engine of a hardware network stack. The host writes one-byte commands into a command register. The block then holds an 8-bit status byte that shows the connection state of the socket. A TCP socket moves through the open, listen, connect and teardown states. A socket can also be opened as a UDP, IP-raw, MAC-raw or PPPoE socket. The block does not build or parse packets. Network happenings come in as single-cycle event pulses: SYN seen, SYN/ACK seen, ACK of our SYN/ACK, RST seen, FIN seen, FIN/ACK seen, ARP timeout, TCP timeout, data received and transmit done. Packets the block wants sent leave as single-cycle request pulses.

A written command is latched for one cycle and consumed on the next clock edge. The status byte, the interrupt flags and the request pulses all change on that same edge. The interrupt flags are sticky. Software clears a flag by writing a one to its bit. A mask selects which flags drive the socket interrupt line.

Several things can arrive in the same cycle. A pending CLOSE command wins first. A timeout comes next, then any other pending command, and network events come last.

Top module: `sockfsm_top`

## Requirements
- R1: After reset the status byte is 0x00, the command readback is 0x00, all interrupt flags are 0 and the interrupt line is low.
- R2: OPEN (0x01) is accepted only in status 0x00. The protocol field selects the new status: 1 gives 0x13, 2 gives 0x22, 3 gives 0x32, 4 gives 0x42 and 5 gives 0x5F. Any other field value leaves the status unchanged.
- R3: OPEN with protocol 4 takes effect only on the socket whose index equals the raw-socket index parameter. On any other socket the status stays 0x00.
- R4: A written command reads back for exactly one cycle. From the next edge on, the readback is 0x00, whether the command was accepted or ignored.
- R5: LISTEN (0x02) in 0x13 gives 0x14. A SYN event in 0x14 gives 0x16 and a one-cycle SYN/ACK request. An ACK event in 0x16 gives 0x17 and sets flag bit 0 (connected).
- R6: CONNECT (0x04) in 0x13 gives 0x15 and a one-cycle SYN request. A SYN/ACK event in 0x15 gives 0x17 and sets flag bit 0. An RST event in 0x15 gives 0x00.
- R7: A command that is not valid in the current status changes neither the status nor the flags. Examples are LISTEN in 0x00, CONNECT or DISCON in 0x22, and DISCON in 0x13. An event that does not apply to the current status is ignored in the same way.
- R8: Active close: DISCON (0x08) in 0x17 gives 0x18 and a one-cycle FIN request. FIN/ACK in 0x18 gives 0x1B, while FIN in 0x18 gives 0x1A, and FIN/ACK in 0x1A gives 0x1B. Status 0x1B lasts TW_HOLD cycles and then becomes 0x00.
- R9: Passive close: FIN in 0x17 gives 0x1C and sets flag bit 1 (disconnected). DISCON in 0x1C gives 0x1D and a one-cycle FIN request. FIN/ACK in 0x1D gives 0x00.
- R10: CLOSE (0x10) gives 0x00 from every status and sets no flag.
- R11: An ARP timeout or a TCP timeout in any status other than 0x00 gives 0x00 and sets flag bit 3 (timeout). In status 0x00 a timeout has no effect.
- R12: A data-received event sets flag bit 2 and a transmit-done event sets flag bit 4, but only while the status is not 0x00.
- R13: Writing the clear register clears each flag whose bit is 1 in the written value and leaves the other flags alone. A flag that is set in the same cycle stays set.
- R14: The interrupt line is high exactly when some flag is 1 and its mask bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command code written |
| proto_sel | input | 4 | Protocol field of the socket mode register |
| ev_syn | input | 1 | SYN received |
| ev_synack | input | 1 | SYN/ACK received |
| ev_ack | input | 1 | ACK of our SYN/ACK received |
| ev_rst | input | 1 | RST received |
| ev_fin | input | 1 | FIN received |
| ev_finack | input | 1 | FIN/ACK received |
| ev_arp_to | input | 1 | ARP timeout |
| ev_tcp_to | input | 1 | TCP timeout |
| ev_rx_data | input | 1 | Data received into the socket |
| ev_tx_done | input | 1 | Transmission completed |
| int_clr_wr | input | 1 | Flag clear strobe |
| int_clr_data | input | 8 | Flags to clear, one per bit |
| int_mask | input | 8 | Interrupt mask |
| cmd_rdata | output | 8 | Command register readback |
| sock_status | output | 8 | Status byte |
| int_flags | output | 8 | Sticky interrupt flags |
| sock_irq | output | 1 | Masked interrupt line |
| req_syn | output | 1 | Send SYN request pulse |
| req_synack | output | 1 | Send SYN/ACK request pulse |
| req_fin | output | 1 | Send FIN request pulse |

## Verification
The bench builds two copies of the block. The first uses socket index 0 and a TIME_WAIT hold of 4 cycles. With a short hold, the bench can count the exact cycle in which status 0x1B falls to 0x00. The second copy uses socket index 1 and receives the same stimulus. Putting the two side by side shows that the MAC-raw open is refused on the second copy, while every other transition matches the first.

// File: rtl/sockfsm_pkg.sv
`timescale 1ns/1ps
// sockfsm_pkg: status encodings, command codes and flag bit positions
// shared by the socket controller. Assumes 8-bit host registers.
package sockfsm_pkg;
    localparam int REG_W = 8;
    localparam int PROTO_W = 4;

    typedef enum logic [REG_W-1:0] {
        ST_CLOSED    = 8'h00,
        ST_INIT      = 8'h13,
        ST_LISTEN    = 8'h14,
        ST_SYNSENT   = 8'h15,
        ST_SYNRECV   = 8'h16,
        ST_EST       = 8'h17,
        ST_FINWAIT   = 8'h18,
        ST_CLOSING   = 8'h1A,
        ST_TIMEWAIT  = 8'h1B,
        ST_CLOSEWAIT = 8'h1C,
        ST_LASTACK   = 8'h1D,
        ST_UDP       = 8'h22,
        ST_IPRAW     = 8'h32,
        ST_MACRAW    = 8'h42,
        ST_PPPOE     = 8'h5F
    } sock_state_e;

    localparam logic [REG_W-1:0] CMD_OPEN    = 8'h01;
    localparam logic [REG_W-1:0] CMD_LISTEN  = 8'h02;
    localparam logic [REG_W-1:0] CMD_CONNECT = 8'h04;
    localparam logic [REG_W-1:0] CMD_DISCON  = 8'h08;
    localparam logic [REG_W-1:0] CMD_CLOSE   = 8'h10;

    localparam int FLG_CON     = 0;
    localparam int FLG_DISCON  = 1;
    localparam int FLG_RECV    = 2;
    localparam int FLG_TIMEOUT = 3;
    localparam int FLG_SENDOK  = 4;
endpackage

// File: rtl/sockfsm_cmd_latch.sv
`timescale 1ns/1ps
// sockfsm_cmd_latch: holds a written command for one cycle so the state
// engine can consume it on the next edge; reads back 0 once consumed.
// Assumes the host never relies on a command surviving more than a cycle.
module sockfsm_cmd_latch
    import sockfsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] cmd_o
);
    // Capture on write, self-clear the cycle after.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmd_o <= '0;
        else if (wr_i) cmd_o <= wdata_i;
        else           cmd_o <= '0;
    end
endmodule

// File: rtl/sockfsm_state.sv
`timescale 1ns/1ps
// sockfsm_state: connection state engine. Decodes the pending command and
// the event pulses, updates the status, emits flag-set pulses and packet
// requests. Priority: CLOSE, then timeouts, then other commands, then events.
// Assumes event inputs are single-cycle pulses.
module sockfsm_state
    import sockfsm_pkg::*;
#(
    parameter int SOCK_IDX     = 0,
    parameter int RAW_SOCK_IDX = 0,
    parameter int TW_HOLD      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   cmd_i,
    input  logic [PROTO_W-1:0] proto_i,
    input  logic               syn_i,
    input  logic               synack_i,
    input  logic               ack_i,
    input  logic               rst_i,
    input  logic               fin_i,
    input  logic               finack_i,
    input  logic               arp_to_i,
    input  logic               tcp_to_i,
    input  logic               rx_i,
    input  logic               txdone_i,
    output sock_state_e        state_o,
    output logic [REG_W-1:0]   flag_set_o,
    output logic               req_syn_o,
    output logic               req_synack_o,
    output logic               req_fin_o
);
    localparam int  TW_CW  = (TW_HOLD > 1) ? $clog2(TW_HOLD) : 1;
    localparam logic [TW_CW-1:0] TW_LOAD = TW_CW'(TW_HOLD - 1);
    localparam bit  RAW_OK = (SOCK_IDX == RAW_SOCK_IDX);

    sock_state_e       state_q, nxt;
    logic [TW_CW-1:0]  tw_cnt_q;
    logic              syn_n, synack_n, fin_n;
    logic              cmd_pend, any_to;

    assign cmd_pend = (cmd_i != '0);
    assign any_to   = arp_to_i | tcp_to_i;

    // Next-state, flag-set and request decode.
    always_comb begin
        nxt        = state_q;
        flag_set_o = '0;
        syn_n      = 1'b0;
        synack_n   = 1'b0;
        fin_n      = 1'b0;
        if (cmd_pend && cmd_i == CMD_CLOSE) begin
            nxt = ST_CLOSED;
        end else if (any_to && state_q != ST_CLOSED) begin
            nxt = ST_CLOSED;
            flag_set_o[FLG_TIMEOUT] = 1'b1;
        end else if (cmd_pend) begin
            case (cmd_i)
                CMD_OPEN: if (state_q == ST_CLOSED) begin
                    case (proto_i)
                        4'd1:    nxt = ST_INIT;
                        4'd2:    nxt = ST_UDP;
                        4'd3:    nxt = ST_IPRAW;
                        4'd4:    if (RAW_OK) nxt = ST_MACRAW;
                        4'd5:    nxt = ST_PPPOE;
                        default: nxt = state_q;
                    endcase
                end
                CMD_LISTEN:  if (state_q == ST_INIT) nxt = ST_LISTEN;
                CMD_CONNECT: if (state_q == ST_INIT) begin
                    nxt   = ST_SYNSENT;
                    syn_n = 1'b1;
                end
                CMD_DISCON: begin
                    if (state_q == ST_EST) begin
                        nxt   = ST_FINWAIT;
                        fin_n = 1'b1;
                    end else if (state_q == ST_CLOSEWAIT) begin
                        nxt   = ST_LASTACK;
                        fin_n = 1'b1;
                    end
                end
                default: nxt = state_q;
            endcase
        end else begin
            case (state_q)
                ST_LISTEN: if (syn_i) begin
                    nxt      = ST_SYNRECV;
                    synack_n = 1'b1;
                end
                ST_SYNSENT: begin
                    if (synack_i) begin
                        nxt = ST_EST;
                        flag_set_o[FLG_CON] = 1'b1;
                    end else if (rst_i) nxt = ST_CLOSED;
                end
                ST_SYNRECV: begin
                    if (ack_i) begin
                        nxt = ST_EST;
                        flag_set_o[FLG_CON] = 1'b1;
                    end else if (rst_i) nxt = ST_CLOSED;
                end
                ST_EST: begin
                    if (rst_i) begin
                        nxt = ST_CLOSED;
                        flag_set_o[FLG_DISCON] = 1'b1;
                    end else if (fin_i) begin
                        nxt = ST_CLOSEWAIT;
                        flag_set_o[FLG_DISCON] = 1'b1;
                    end
                end
                ST_FINWAIT: begin
                    if (finack_i)   nxt = ST_TIMEWAIT;
                    else if (fin_i) nxt = ST_CLOSING;
                end
                ST_CLOSING:  if (finack_i) nxt = ST_TIMEWAIT;
                ST_LASTACK:  if (finack_i) nxt = ST_CLOSED;
                ST_TIMEWAIT: if (tw_cnt_q == '0) nxt = ST_CLOSED;
                default:     nxt = state_q;
            endcase
            if (state_q != ST_CLOSED) begin
                flag_set_o[FLG_RECV]   = rx_i;
                flag_set_o[FLG_SENDOK] = txdone_i;
            end
        end
    end

    // State and request pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_CLOSED;
            req_syn_o    <= 1'b0;
            req_synack_o <= 1'b0;
            req_fin_o    <= 1'b0;
        end else begin
            state_q      <= nxt;
            req_syn_o    <= syn_n;
            req_synack_o <= synack_n;
            req_fin_o    <= fin_n;
        end
    end

    // TIME_WAIT dwell counter: reloads outside TIME_WAIT, counts down inside.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tw_cnt_q <= TW_LOAD;
        else if (state_q != ST_TIMEWAIT) tw_cnt_q <= TW_LOAD;
        else if (tw_cnt_q != '0)        tw_cnt_q <= tw_cnt_q - 1'b1;
    end

    assign state_o = state_q;

    // R10: a pending CLOSE always lands in the closed state.
    a_r10_close_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_CLOSE) |=> (state_q == ST_CLOSED));

    // R11: a timeout in an open state lands in the closed state.
    a_r11_timeout_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (any_to && state_q != ST_CLOSED) |=> (state_q == ST_CLOSED));

    // R3: MAC-raw state only reachable on the raw-capable socket.
    a_r3_raw_socket_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!RAW_OK) |-> (state_q != ST_MACRAW));

    // R6: a SYN request is only ever issued alongside SYNSENT.
    a_r6_syn_with_synsent: assert property (@(posedge clk) disable iff (!rst_n)
        req_syn_o |-> (state_q == ST_SYNSENT));
endmodule

// File: rtl/sockfsm_irq.sv
`timescale 1ns/1ps
// sockfsm_irq: sticky interrupt flags with write-one-to-clear and a masked
// interrupt output. A set pulse wins over a clear of the same bit.
module sockfsm_irq
    import sockfsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic [REG_W-1:0] clr_data_i,
    input  logic [REG_W-1:0] mask_i,
    output logic [REG_W-1:0] flags_o,
    output logic             irq_o
);
    logic [REG_W-1:0] clr_v;
    assign clr_v = clr_wr_i ? clr_data_i : '0;

    // Flag update: clear requested bits, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_v) | set_i;
    end

    assign irq_o = |(flags_o & mask_i);

    // R13: bits cleared without a same-cycle set are zero afterwards.
    a_r13_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((flags_o & $past(clr_data_i & ~set_i)) == '0));
endmodule

// File: rtl/sockfsm_top.sv
`timescale 1ns/1ps
// sockfsm_top: per-socket command/status controller. Connects the command
// latch, the state engine and the interrupt flag block.
// Assumes one socket per instance; SOCK_IDX names this socket.
module sockfsm_top
    import sockfsm_pkg::*;
#(
    parameter int SOCK_IDX     = 0,
    parameter int RAW_SOCK_IDX = 0,
    parameter int TW_HOLD      = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_wr,
    input  logic [7:0]   cmd_wdata,
    input  logic [3:0]   proto_sel,
    input  logic         ev_syn,
    input  logic         ev_synack,
    input  logic         ev_ack,
    input  logic         ev_rst,
    input  logic         ev_fin,
    input  logic         ev_finack,
    input  logic         ev_arp_to,
    input  logic         ev_tcp_to,
    input  logic         ev_rx_data,
    input  logic         ev_tx_done,
    input  logic         int_clr_wr,
    input  logic [7:0]   int_clr_data,
    input  logic [7:0]   int_mask,
    output logic [7:0]   cmd_rdata,
    output logic [7:0]   sock_status,
    output logic [7:0]   int_flags,
    output logic         sock_irq,
    output logic         req_syn,
    output logic         req_synack,
    output logic         req_fin
);
    logic [REG_W-1:0] cmd_q;
    logic [REG_W-1:0] set_v;
    sock_state_e      st;

    sockfsm_cmd_latch u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cmd_wr),
        .wdata_i (cmd_wdata),
        .cmd_o   (cmd_q)
    );

    sockfsm_state #(
        .SOCK_IDX     (SOCK_IDX),
        .RAW_SOCK_IDX (RAW_SOCK_IDX),
        .TW_HOLD      (TW_HOLD)
    ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd_q),
        .proto_i      (proto_sel),
        .syn_i        (ev_syn),
        .synack_i     (ev_synack),
        .ack_i        (ev_ack),
        .rst_i        (ev_rst),
        .fin_i        (ev_fin),
        .finack_i     (ev_finack),
        .arp_to_i     (ev_arp_to),
        .tcp_to_i     (ev_tcp_to),
        .rx_i         (ev_rx_data),
        .txdone_i     (ev_tx_done),
        .state_o      (st),
        .flag_set_o   (set_v),
        .req_syn_o    (req_syn),
        .req_synack_o (req_synack),
        .req_fin_o    (req_fin)
    );

    sockfsm_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_v),
        .clr_wr_i   (int_clr_wr),
        .clr_data_i (int_clr_data),
        .mask_i     (int_mask),
        .flags_o    (int_flags),
        .irq_o      (sock_irq)
    );

    assign cmd_rdata   = cmd_q;
    assign sock_status = st;

    // R4: a command left unwritten reads back zero on the next cycle.
    a_r4_cmd_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata != 8'h00 && !cmd_wr) |=> (cmd_rdata == 8'h00));

    // R5: the connected flag only rises together with the ESTABLISHED status.
    a_r5_con_with_est: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flags[FLG_CON]) |-> (sock_status == 8'h17));
endmodule

// File: tb/sockfsm_top_tb_top.sv
`timescale 1ns/1ps
module sockfsm_top_tb_top;
    localparam int TW = 4;
    localparam int E_SYN = 0, E_SYNACK = 1, E_ACK = 2, E_RST = 3, E_FIN = 4,
                   E_FINACK = 5, E_ARPTO = 6, E_TCPTO = 7, E_RX = 8, E_TXD = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic [3:0] proto_sel = 4'd0;
    logic [9:0] ev = '0;
    logic       int_clr_wr = 1'b0;
    logic [7:0] int_clr_data = 8'h00;
    logic [7:0] int_mask = 8'h00;

    logic [7:0] cmd_rdata, sock_status, int_flags;
    logic       sock_irq, req_syn, req_synack, req_fin;
    logic [7:0] cmd_rdata1, sock_status1, int_flags1;
    logic       sock_irq1, req_syn1, req_synack1, req_fin1;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sockfsm_top #(.SOCK_IDX(0), .RAW_SOCK_IDX(0), .TW_HOLD(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .proto_sel(proto_sel), .ev_syn(ev[E_SYN]), .ev_synack(ev[E_SYNACK]),
        .ev_ack(ev[E_ACK]), .ev_rst(ev[E_RST]), .ev_fin(ev[E_FIN]),
        .ev_finack(ev[E_FINACK]), .ev_arp_to(ev[E_ARPTO]), .ev_tcp_to(ev[E_TCPTO]),
        .ev_rx_data(ev[E_RX]), .ev_tx_done(ev[E_TXD]), .int_clr_wr(int_clr_wr),
        .int_clr_data(int_clr_data), .int_mask(int_mask), .cmd_rdata(cmd_rdata),
        .sock_status(sock_status), .int_flags(int_flags), .sock_irq(sock_irq),
        .req_syn(req_syn), .req_synack(req_synack), .req_fin(req_fin));

    sockfsm_top #(.SOCK_IDX(1), .RAW_SOCK_IDX(0), .TW_HOLD(TW)) dut1_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .proto_sel(proto_sel), .ev_syn(ev[E_SYN]), .ev_synack(ev[E_SYNACK]),
        .ev_ack(ev[E_ACK]), .ev_rst(ev[E_RST]), .ev_fin(ev[E_FIN]),
        .ev_finack(ev[E_FINACK]), .ev_arp_to(ev[E_ARPTO]), .ev_tcp_to(ev[E_TCPTO]),
        .ev_rx_data(ev[E_RX]), .ev_tx_done(ev[E_TXD]), .int_clr_wr(int_clr_wr),
        .int_clr_data(int_clr_data), .int_mask(int_mask), .cmd_rdata(cmd_rdata1),
        .sock_status(sock_status1), .int_flags(int_flags1), .sock_irq(sock_irq1),
        .req_syn(req_syn1), .req_synack(req_synack1), .req_fin(req_fin1));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write a command; status is valid when the task returns.
    task automatic issue(input logic [7:0] c, input logic [3:0] p);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = c; proto_sel = p;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_wdata = 8'h00;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [9:0] v);
        @(negedge clk);
        ev = v;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic clr(input logic [7:0] v);
        @(negedge clk);
        int_clr_wr = 1'b1; int_clr_data = v;
        @(negedge clk);
        int_clr_wr = 1'b0; int_clr_data = 8'h00;
    endtask

    task automatic establish();
        issue(8'h01, 4'd1);
        issue(8'h04, 4'd1);
        pulse(10'(1) << E_SYNACK);
    endtask

    task automatic t_reset();
        chk("R1 status", sock_status, 8'h00);
        chk("R1 cmd", cmd_rdata, 8'h00);
        chk("R1 flags", int_flags, 8'h00);
        chk("R1 irq", {7'd0, sock_irq}, 8'h00);
    endtask

    task automatic t_open_modes();
        logic [7:0] exp [1:5];
        exp[1] = 8'h13; exp[2] = 8'h22; exp[3] = 8'h32; exp[4] = 8'h42; exp[5] = 8'h5F;
        for (int p = 1; p <= 5; p++) begin
            issue(8'h01, 4'(p));
            chk($sformatf("R2 open proto %0d", p), sock_status, exp[p]);
            issue(8'h10, 4'd0);
        end
        issue(8'h01, 4'd0);
        chk("R2 open proto 0", sock_status, 8'h00);
        issue(8'h01, 4'd6);
        chk("R2 open proto 6", sock_status, 8'h00);
    endtask

    task automatic t_raw_socket();
        issue(8'h01, 4'd4);
        chk("R3 raw on socket 0", sock_status, 8'h42);
        chk("R3 raw refused socket 1", sock_status1, 8'h00);
        issue(8'h10, 4'd0);
        issue(8'h01, 4'd2);
        chk("R3 udp on socket 1", sock_status1, 8'h22);
        issue(8'h10, 4'd0);
    endtask

    task automatic t_readback();
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 8'h02; proto_sel = 4'd1;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_wdata = 8'h00;
        chk("R4 readback held", cmd_rdata, 8'h02);
        @(negedge clk);
        chk("R4 readback cleared (ignored cmd)", cmd_rdata, 8'h00);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 8'h01;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_wdata = 8'h00;
        chk("R4 readback open", cmd_rdata, 8'h01);
        @(negedge clk);
        chk("R4 readback cleared (accepted)", cmd_rdata, 8'h00);
        issue(8'h10, 4'd0);
    endtask

    task automatic t_listen();
        clr(8'hFF);
        issue(8'h01, 4'd1);
        issue(8'h02, 4'd1);
        chk("R5 listen", sock_status, 8'h14);
        @(negedge clk);
        ev = 10'(1) << E_SYN;
        @(negedge clk);
        ev = '0;
        chk("R5 synrecv", sock_status, 8'h16);
        chk("R5 synack req", {7'd0, req_synack}, 8'h01);
        @(negedge clk);
        chk("R5 synack req one cycle", {7'd0, req_synack}, 8'h00);
        pulse(10'(1) << E_ACK);
        chk("R5 established", sock_status, 8'h17);
        chk("R5 con flag", int_flags, 8'h01);
        issue(8'h10, 4'd0);
        clr(8'hFF);
    endtask

    task automatic t_connect();
        issue(8'h01, 4'd1);
        issue(8'h04, 4'd1);
        chk("R6 synsent", sock_status, 8'h15);
        chk("R6 syn req", {7'd0, req_syn}, 8'h01);
        pulse(10'(1) << E_SYNACK);
        chk("R6 established", sock_status, 8'h17);
        chk("R6 con flag", int_flags, 8'h01);
        issue(8'h10, 4'd0);
        clr(8'hFF);
        issue(8'h01, 4'd1);
        issue(8'h04, 4'd1);
        pulse(10'(1) << E_RST);
        chk("R6 rst closes", sock_status, 8'h00);
        chk("R6 rst no flag", int_flags, 8'h00);
    endtask

    task automatic t_invalid();
        issue(8'h02, 4'd1);
        chk("R7 listen in closed", sock_status, 8'h00);
        issue(8'h01, 4'd2);
        issue(8'h04, 4'd2);
        chk("R7 connect in udp", sock_status, 8'h22);
        issue(8'h08, 4'd2);
        chk("R7 discon in udp", sock_status, 8'h22);
        pulse(10'(1) << E_SYN);
        chk("R7 syn in udp", sock_status, 8'h22);
        issue(8'h10, 4'd0);
        issue(8'h01, 4'd1);
        issue(8'h08, 4'd1);
        chk("R7 discon in init", sock_status, 8'h13);
        pulse(10'(1) << E_ACK);
        chk("R7 ack in init", sock_status, 8'h13);
        chk("R7 no flags", int_flags, 8'h00);
        issue(8'h10, 4'd0);
    endtask

    task automatic t_active_close();
        establish();
        clr(8'hFF);
        issue(8'h08, 4'd1);
        chk("R8 fin_wait", sock_status, 8'h18);
        chk("R8 fin req", {7'd0, req_fin}, 8'h01);
        pulse(10'(1) << E_FINACK);
        chk("R8 time_wait entry", sock_status, 8'h1B);
        repeat (TW - 1) @(negedge clk);
        chk("R8 time_wait last cycle", sock_status, 8'h1B);
        @(negedge clk);
        chk("R8 time_wait expiry", sock_status, 8'h00);
        establish();
        issue(8'h08, 4'd1);
        pulse(10'(1) << E_FIN);
        chk("R8 closing", sock_status, 8'h1A);
        pulse(10'(1) << E_FINACK);
        chk("R8 closing to time_wait", sock_status, 8'h1B);
        issue(8'h10, 4'd0);
        clr(8'hFF);
    endtask

    task automatic t_passive_close();
        establish();
        clr(8'hFF);
        pulse(10'(1) << E_FIN);
        chk("R9 close_wait", sock_status, 8'h1C);
        chk("R9 discon flag", int_flags, 8'h02);
        issue(8'h08, 4'd1);
        chk("R9 last_ack", sock_status, 8'h1D);
        chk("R9 fin req", {7'd0, req_fin}, 8'h01);
        pulse(10'(1) << E_FINACK);
        chk("R9 closed", sock_status, 8'h00);
        clr(8'hFF);
    endtask

    task automatic t_close_any();
        issue(8'h01, 4'd1);
        issue(8'h02, 4'd1);
        issue(8'h10, 4'd0);
        chk("R10 close from listen", sock_status, 8'h00);
        chk("R10 no flag", int_flags, 8'h00);
        establish();
        clr(8'hFF);
        issue(8'h10, 4'd0);
        chk("R10 close from established", sock_status, 8'h00);
        chk("R10 no flag est", int_flags, 8'h00);
    endtask

    task automatic t_timeout();
        issue(8'h01, 4'd1);
        issue(8'h04, 4'd1);
        pulse(10'(1) << E_TCPTO);
        chk("R11 tcp timeout", sock_status, 8'h00);
        chk("R11 timeout flag", int_flags, 8'h08);
        clr(8'hFF);
        issue(8'h01, 4'd2);
        pulse(10'(1) << E_ARPTO);
        chk("R11 arp timeout udp", sock_status, 8'h00);
        chk("R11 timeout flag udp", int_flags, 8'h08);
        clr(8'hFF);
        pulse(10'(1) << E_TCPTO);
        chk("R11 timeout in closed", int_flags, 8'h00);
    endtask

    task automatic t_data_flags();
        pulse(10'(1) << E_RX);
        chk("R12 rx in closed", int_flags, 8'h00);
        issue(8'h01, 4'd2);
        pulse(10'(1) << E_RX);
        chk("R12 recv flag", int_flags, 8'h04);
        pulse(10'(1) << E_TXD);
        chk("R12 sendok flag", int_flags, 8'h14);
    endtask

    task automatic t_clear();
        clr(8'h04);
        chk("R13 partial clear", int_flags, 8'h10);
        @(negedge clk);
        ev = 10'(1) << E_RX;
        int_clr_wr = 1'b1; int_clr_data = 8'h04;
        @(negedge clk);
        ev = '0; int_clr_wr = 1'b0; int_clr_data = 8'h00;
        chk("R13 set wins", int_flags, 8'h14);
        clr(8'h00);
        chk("R13 zero write", int_flags, 8'h14);
        clr(8'h04);
    endtask

    task automatic t_mask();
        int_mask = 8'h00;
        @(negedge clk);
        chk("R14 masked off", {7'd0, sock_irq}, 8'h00);
        int_mask = 8'h10;
        @(negedge clk);
        chk("R14 masked on", {7'd0, sock_irq}, 8'h01);
        int_mask = 8'hEF;
        @(negedge clk);
        chk("R14 other bits", {7'd0, sock_irq}, 8'h00);
        int_mask = 8'h00;
        issue(8'h10, 4'd0);
        clr(8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open_modes();
        t_raw_socket();
        t_readback();
        t_listen();
        t_connect();
        t_invalid();
        t_active_close();
        t_passive_close();
        t_close_any();
        t_timeout();
        t_data_flags();
        t_clear();
        t_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule